// File: doc/BRIEF.md
# Protected Register Bank Key Gate

This block sits beside a bank of configuration registers that must not change by accident. Software opens the bank by writing two fixed keys, one after the other, to a dedicated key register on a simple write bus. The first key is 0xCA and the second is 0x53. While the bank is open, the block passes every bus write aimed at the protected address window on to the registers through a write-enable qualifier. While the bank is shut, it drops those writes without any error.

Only writes to the key register move the sequence detector. Writes to other addresses can fall between the two keys and leave the sequence intact. Once the bank is open, any key-register write shuts it again, and 0xFF is the usual value for that. A wrong value at any step sends the detector back to the shut idle state. A small read port returns a status word. That word shows whether the bank is open and whether the first key has been seen. The key register itself always reads as zero.

Top module: `wprot_keygate`

## Requirements
- R1: After reset, and whenever reset is applied, the bank is shut (`unlocked` = 0), the first-key flag is clear and `prot_wr_en` stays 0.
- R2: A key-register write of exactly 0xCA, followed by the next key-register write of exactly 0x53, opens the bank. `unlocked` goes to 1 in the cycle after the clock edge that takes the 0x53 write.
- R3: `prot_wr_en` is 1 only when three conditions hold together: `bus_wr` is high, `bus_addr` lies in [PROT_BASE, PROT_BASE+PROT_SIZE), and the bank is open. Protected writes made while the bank is shut are dropped.
- R4: A key-register write of 0xFF while the bank is open shuts it from the next cycle.
- R5: While the bank is open, a key-register write of any other value (0x00 or 0xCA, for example) also shuts it. Reopening then takes a new 0xCA, 0x53 pair.
- R6: A key-register write of 0x53 with no 0xCA just before it leaves the bank shut and the detector idle.
- R7: After 0xCA, any key-register write other than 0x53, including a second 0xCA, sends the detector back to idle. A later single 0x53 then does not open the bank.
- R8: Writes to non-key addresses, protected or not, do not change the detector state. They can fall between the two keys without breaking the sequence.
- R9: Key values are compared against the whole data word, so the upper bits must be zero. A write of 0x1CA is not the first key and leaves the detector idle.
- R10: Reads at STAT_ADDR return bit 0 = bank open and bit 1 = first key seen, with all other bits zero. Reads at KEY_ADDR, and at every other address, return zero.
- R11: Key-register data presented while `bus_wr` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | AW | Write address |
| bus_wdata | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data: status word or zero |
| prot_wr_en | output | 1 | Write-enable qualifier for the protected bank |
| unlocked | output | 1 | Bank-open status |

## Verification
The bench uses the default parameters: AW = 8, DW = 32, key register at 0x24, status at 0x0C, and a protected window of 16 words at 0x40. That window is aligned and a power of two, so the address decoder takes its mask-compare variant. The window edges 0x3F, 0x40, 0x4F and 0x50 are all in reach. The 32-bit data word lets the bench show that a key with a stray upper bit (0x1CA) is rejected.

// File: rtl/wpk_pkg.sv
package wpk_pkg;

   typedef enum logic [1:0] {
      WPK_IDLE  = 2'd0,
      WPK_ARMED = 2'd1,
      WPK_OPEN  = 2'd2
   } wpk_state_e;

   // Next state of the key detector; only key-register writes move it.
   function automatic wpk_state_e wpk_next(wpk_state_e cur, logic key_wr,
                                           logic is_first, logic is_second);
      wpk_state_e nxt;
      nxt = cur;
      if (key_wr) begin
         case (cur)
            WPK_IDLE:  nxt = is_first  ? WPK_ARMED : WPK_IDLE;
            WPK_ARMED: nxt = is_second ? WPK_OPEN  : WPK_IDLE;
            default:   nxt = WPK_IDLE;
         endcase
      end
      return nxt;
   endfunction

endpackage

// File: rtl/wpk_addr_dec.sv
module wpk_addr_dec #(
   parameter int unsigned AW        = 8,
   parameter int unsigned KEY_ADDR  = 'h24,
   parameter int unsigned PROT_BASE = 'h40,
   parameter int unsigned PROT_SIZE = 16
) (
   input  logic [AW-1:0] addr,
   output logic          is_key,
   output logic          is_prot
);
   localparam bit ALIGNED = ((PROT_SIZE & (PROT_SIZE - 1)) == 0) &&
                            ((PROT_BASE % PROT_SIZE) == 0);

   assign is_key = (addr == AW'(KEY_ADDR));

   generate
      if (ALIGNED) begin : g_mask
         localparam logic [AW-1:0] MASK = AW'(PROT_SIZE - 1);
         assign is_prot = ((addr & ~MASK) == AW'(PROT_BASE));
      end else begin : g_range
         logic [AW:0] a_ext;
         assign a_ext   = {1'b0, addr};
         assign is_prot = (a_ext >= (AW+1)'(PROT_BASE)) &&
                          (a_ext <  (AW+1)'(PROT_BASE + PROT_SIZE));
      end
   endgenerate
endmodule

// File: rtl/wpk_seq.sv
module wpk_seq
   import wpk_pkg::*;
#(
   parameter int unsigned DW         = 32,
   parameter int unsigned KEY_FIRST  = 'hCA,
   parameter int unsigned KEY_SECOND = 'h53
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          key_wr,
   input  logic [DW-1:0] wdata,
   output logic          open_q,
   output logic          armed_q
);
   wpk_state_e state_q, state_d;
   logic       hit_first, hit_second;

   assign hit_first  = (wdata == DW'(KEY_FIRST));
   assign hit_second = (wdata == DW'(KEY_SECOND));

   always_comb state_d = wpk_next(state_q, key_wr, hit_first, hit_second);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= WPK_IDLE;
      else        state_q <= state_d;
   end

   assign open_q  = (state_q == WPK_OPEN);
   assign armed_q = (state_q == WPK_ARMED);
endmodule

// File: rtl/wpk_rdmux.sv
module wpk_rdmux #(
   parameter int unsigned AW        = 8,
   parameter int unsigned DW        = 32,
   parameter int unsigned STAT_ADDR = 'h0C
) (
   input  logic [AW-1:0] rd_addr,
   input  logic          open_q,
   input  logic          armed_q,
   output logic [DW-1:0] rd_data
);
   localparam int unsigned PAD = DW - 2;

   always_comb begin
      if (rd_addr == AW'(STAT_ADDR)) rd_data = {{PAD{1'b0}}, armed_q, open_q};
      else                           rd_data = '0;
   end
endmodule

// File: rtl/wprot_keygate.sv
module wprot_keygate #(
   parameter int unsigned AW         = 8,
   parameter int unsigned DW         = 32,
   parameter int unsigned KEY_ADDR   = 'h24,
   parameter int unsigned STAT_ADDR  = 'h0C,
   parameter int unsigned PROT_BASE  = 'h40,
   parameter int unsigned PROT_SIZE  = 16,
   parameter int unsigned KEY_FIRST  = 'hCA,
   parameter int unsigned KEY_SECOND = 'h53
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic          prot_wr_en,
   output logic          unlocked
);
   localparam longint unsigned ASPACE = 64'd1 << AW;

   initial begin : elab_checks
      if (DW < 8)                              $error("DW must hold an 8-bit key");
      if (PROT_SIZE == 0)                      $error("PROT_SIZE must be nonzero");
      if (PROT_BASE + PROT_SIZE > ASPACE)      $error("protected window exceeds address space");
      if (KEY_ADDR >= PROT_BASE && KEY_ADDR < PROT_BASE + PROT_SIZE)
                                               $error("key register inside protected window");
      if (KEY_ADDR == STAT_ADDR)               $error("key and status addresses collide");
      if (KEY_FIRST == KEY_SECOND)             $error("the two keys must differ");
   end

   logic is_key, is_prot, open_q, armed_q;

   wpk_addr_dec #(
      .AW(AW), .KEY_ADDR(KEY_ADDR), .PROT_BASE(PROT_BASE), .PROT_SIZE(PROT_SIZE)
   ) u_dec (
      .addr(bus_addr), .is_key(is_key), .is_prot(is_prot)
   );

   wpk_seq #(
      .DW(DW), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .key_wr(bus_wr && is_key), .wdata(bus_wdata),
      .open_q(open_q), .armed_q(armed_q)
   );

   wpk_rdmux #(
      .AW(AW), .DW(DW), .STAT_ADDR(STAT_ADDR)
   ) u_rd (
      .rd_addr(rd_addr), .open_q(open_q), .armed_q(armed_q), .rd_data(rd_data)
   );

   assign prot_wr_en = bus_wr && is_prot && open_q;
   assign unlocked   = open_q;
endmodule

// File: rtl/wpk_chk.sv
module wpk_chk #(
   parameter int unsigned AW         = 8,
   parameter int unsigned DW         = 32,
   parameter int unsigned KEY_ADDR   = 'h24,
   parameter int unsigned KEY_SECOND = 'h53
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_wr,
   input logic [AW-1:0] bus_addr,
   input logic [DW-1:0] bus_wdata,
   input logic [AW-1:0] rd_addr,
   input logic [DW-1:0] rd_data,
   input logic          prot_wr_en,
   input logic          unlocked
);
   logic key_wr;
   assign key_wr = bus_wr && (bus_addr == AW'(KEY_ADDR));

   AST_RESET_SHUT: assert property (@(posedge clk) !rst_n |=> !unlocked); // R1
   AST_NO_EN_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |-> !prot_wr_en); // R3
   AST_OPEN_ON_KEY2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(key_wr && bus_wdata == DW'(KEY_SECOND))); // R2
   AST_KEY_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && key_wr) |=> !unlocked); // R5
   AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !key_wr |=> $stable(unlocked)); // R8
   AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == AW'(KEY_ADDR)) |-> (rd_data == '0)); // R10
endmodule

bind wprot_keygate wpk_chk #(
   .AW(AW), .DW(DW), .KEY_ADDR(KEY_ADDR), .KEY_SECOND(KEY_SECOND)
) u_wpk_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
   .prot_wr_en(prot_wr_en), .unlocked(unlocked)
);

// File: tb/tb_wprot_keygate.sv
`timescale 1ns/1ps
module tb_wprot_keygate;
   localparam int AW = 8;
   localparam int DW = 32;
   localparam logic [7:0] KEY = 8'h24;
   localparam logic [7:0] STA = 8'h0C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [AW-1:0] rd_addr = STA;
   logic [DW-1:0] rd_data;
   logic          prot_wr_en, unlocked;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   wprot_keygate dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
      .prot_wr_en(prot_wr_en), .unlocked(unlocked)
   );

   typedef struct packed {
      logic        wr;
      logic [7:0]  addr;
      logic [31:0] data;
      logic        en;
      logic        unl;
      logic        pend;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 8'h24, 32'h000000CA, 1'b0, 1'b0, 1'b1, 4'd2},  // R2 first key
      '{1'b1, 8'h24, 32'h00000053, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 opens
      '{1'b1, 8'h24, 32'h000000FF, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 lock value
      '{1'b1, 8'h24, 32'h00000053, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 lone second key
      '{1'b1, 8'h24, 32'h000000CA, 1'b0, 1'b0, 1'b1, 4'd7},  // R7
      '{1'b1, 8'h24, 32'h000000CA, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 repeated first key
      '{1'b1, 8'h24, 32'h00000053, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 stays shut
      '{1'b1, 8'h24, 32'h000000CA, 1'b0, 1'b0, 1'b1, 4'd8},  // R8
      '{1'b1, 8'h10, 32'h00000055, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 plain address
      '{1'b1, 8'h40, 32'h00000001, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 protected, shut
      '{1'b1, 8'h24, 32'h00000053, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 sequence survived
      '{1'b1, 8'h40, 32'h000000AA, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 low edge
      '{1'b1, 8'h4F, 32'h000000BB, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 high edge
      '{1'b1, 8'h50, 32'h000000CC, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 above window
      '{1'b1, 8'h3F, 32'h000000DD, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 below window
      '{1'b1, 8'h24, 32'h00000000, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 stray value
      '{1'b1, 8'h24, 32'h000001CA, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 upper bit set
      '{1'b0, 8'h24, 32'h000000CA, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 no strobe
      '{1'b1, 8'h24, 32'h000000CA, 1'b0, 1'b0, 1'b1, 4'd2},
      '{1'b1, 8'h24, 32'h00000053, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 reopen
      '{1'b1, 8'h24, 32'h000000CA, 1'b0, 1'b0, 1'b0, 4'd5}   // R5 first key while open
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr_cycle(input logic wr, input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = wr; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   initial begin
      #2000000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state, protected write attempted during reset
      bus_wr = 1'b1; bus_addr = 8'h40; #1;
      check("R1 en in reset", {31'd0, prot_wr_en}, 32'd0);
      bus_wr = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 status after reset", {rd_data[30:0], unlocked}, 32'd0);
      bus_wr = 1'b1; bus_addr = 8'h41; #1;
      check("R1 en after reset", {31'd0, prot_wr_en}, 32'd0);
      bus_wr = 1'b0;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         bus_wr = VEC[i].wr; bus_addr = VEC[i].addr; bus_wdata = VEC[i].data;
         #1;
         check($sformatf("R%0d vec %0d en", VEC[i].req, i), {31'd0, prot_wr_en},
               {31'd0, VEC[i].en});
         @(posedge clk);
         #1 bus_wr = 1'b0;
         @(negedge clk);
         check($sformatf("R%0d vec %0d state", VEC[i].req, i),
               {rd_data[31:0], unlocked} , {31'd0, VEC[i].pend, VEC[i].unl, VEC[i].unl});
      end

      // R10 read-back: open the bank, then read key, status and other addresses
      wr_cycle(1'b1, KEY, 32'hCA);
      wr_cycle(1'b1, KEY, 32'h53);
      @(negedge clk);
      rd_addr = KEY; #1;
      check("R10 key reads zero", rd_data, 32'd0);
      rd_addr = 8'h40; #1;
      check("R10 other reads zero", rd_data, 32'd0);
      rd_addr = STA; #1;
      check("R10 status open", rd_data, 32'd1);

      // R1 reset while open shuts the bank
      rst_n = 1'b0; #1;
      check("R1 reset while open", {31'd0, unlocked}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 status after second reset", rd_data, 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule